// File: doc/BRIEF.md
# 4:2:2 Pixel Port Demultiplexer

This block takes 4:2:2 YCbCr video from a parallel pixel port and turns it into a stream of whole samples. Each sample is one luma value plus the Cb/Cr pair that belongs to its pixel pair. The two pixels of a co-sited pair are emitted on consecutive cycles and carry identical chroma. Two capture layouts exist. In the narrow layout a single byte bus carries all three components, interleaved one byte per clock. In the wide layout the low bus carries luma and the high bus carries alternating chroma, and a new byte pair is taken only on every other clock edge.

A one-cycle line-start pulse restarts component tracking, so the byte after the pulse is always taken as Cb. The pulse is also the only point where a newly requested layout is adopted. The byte present during the pulse cycle is a marker and is not captured. The output side is a valid-only stream: the pixel port cannot be stalled, so there is no ready input and no back-pressure. The consumer must take every sample in the cycle its strobe is high. Between strobes the sample outputs hold their last value.

Top module: `p422_demux`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the valid strobe is low and all sample outputs are zero. After reset the narrow layout (mode_sel value 0) is in force until a line-start pulse adopts another.
- R2: In the narrow layout, captured bytes on lo_byte after a line start (or reset) are taken in the repeating order Cb, Y0, Cr, Y1.
- R3: In the wide layout (mode_sel value 1), bytes are taken only on the first and third edge of each four-edge group. The first edge takes Y0 from lo_byte and Cb from hi_byte. The third edge takes Y1 from lo_byte and Cr from hi_byte. Bus values on the second and fourth edges have no effect.
- R4: Each group of four captured edges yields exactly two strobes, on its third and fourth edge. The first strobe carries Y0 and the second carries Y1, and both carry the group's Cb and Cr.
- R5: The edge that samples line_start high captures nothing and drives the strobe low. The next edge is taken as the start of a new group (Cb).
- R6: A change on mode_sel takes effect only at an edge that samples line_start high. At all other times the layout in force does not change.
- R7: No strobe is issued before a complete Cb, Y, Cr group has been captured after reset or after a line start. A group cut short by a line start emits nothing.
- R8: In the narrow layout the value on hi_byte has no effect on any output.
- R9: When the valid strobe is low, pix_y, pix_cb and pix_cr keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | Requested layout: 0 narrow, 1 wide; adopted at line start |
| line_start | input | 1 | One-cycle pulse marking the cycle before a line's first byte |
| lo_byte | input | DW | Interleaved components (narrow) or luma (wide) |
| hi_byte | input | DW | Interleaved chroma (wide); ignored in narrow |
| pix_y | output | DW | Luma of the current sample |
| pix_cb | output | DW | Cb of the sample's pixel pair |
| pix_cr | output | DW | Cr of the sample's pixel pair |
| pix_valid | output | 1 | One-cycle strobe per sample; no back-pressure |

## Verification
The embedded properties watch, on every cycle, several structural rules. The layout changes only on a line-start edge, and a line-start edge always leaves the strobe low. Strobes come in Y0/Y1 pairs with unchanged chroma, only at the group positions that follow a complete capture, and the sample outputs are frozen between strobes. The bench checks that the right bytes land in the right fields. It covers both layouts, bytes on idle wide-layout edges and on the unused high bus, mode toggling in mid-line, lines cut short in the middle of a group, back-to-back line starts, and the default layout straight out of reset.

// File: rtl/p422_pkg.sv
package p422_pkg;
  localparam int PHASE_W = 2;

  typedef enum logic {
    CAP_NARROW = 1'b0,
    CAP_WIDE   = 1'b1
  } cap_mode_e;

  typedef logic [PHASE_W-1:0] grp_phase_t;

  localparam grp_phase_t PH_FIRST  = 2'd0;
  localparam grp_phase_t PH_SECOND = 2'd1;
  localparam grp_phase_t PH_THIRD  = 2'd2;
  localparam grp_phase_t PH_FOURTH = 2'd3;
endpackage

// File: rtl/p422_seq.sv
module p422_seq
  import p422_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sol,
  input  logic       mode_req,
  output grp_phase_t phase,
  output cap_mode_e  mode_act
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_FIRST;
      mode_act <= CAP_NARROW;
    end else if (sol) begin
      phase    <= PH_FIRST;
      mode_act <= cap_mode_e'(mode_req);
    end else begin
      phase    <= phase + grp_phase_t'(1);
    end
  end

  AST_MODE_ONLY_AT_SOL: assert property (@(posedge clk) disable iff (!rst_n)
    !sol |=> $stable(mode_act)); // R6

endmodule

// File: rtl/p422_capture.sv
module p422_capture
  import p422_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sol,
  input  grp_phase_t    phase,
  input  cap_mode_e     mode_act,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_cb,
  output logic [DW-1:0] out_cr,
  output logic          out_valid
);

  logic [DW-1:0] cb_hold;
  logic [DW-1:0] y0_hold;
  logic [DW-1:0] y1_hold;
  logic          wide;

  assign wide = (mode_act == CAP_WIDE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cb_hold   <= '0;
      y0_hold   <= '0;
      y1_hold   <= '0;
      out_y     <= '0;
      out_cb    <= '0;
      out_cr    <= '0;
      out_valid <= 1'b0;
    end else if (sol) begin
      out_valid <= 1'b0;
    end else begin
      unique case (phase)
        PH_FIRST: begin
          out_valid <= 1'b0;
          cb_hold   <= wide ? hi : lo;
          if (wide) y0_hold <= lo;
        end
        PH_SECOND: begin
          out_valid <= 1'b0;
          if (!wide) y0_hold <= lo;
        end
        PH_THIRD: begin
          out_valid <= 1'b1;
          out_y     <= y0_hold;
          out_cb    <= cb_hold;
          out_cr    <= wide ? hi : lo;
          if (wide) y1_hold <= lo;
        end
        PH_FOURTH: begin
          out_valid <= 1'b1;
          out_y     <= wide ? y1_hold : lo;
        end
      endcase
    end
  end

  AST_SOL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sol |=> !out_valid); // R5

  AST_PAIR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && !sol) |=> out_valid); // R4

  AST_PAIR_CHROMA: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> ($stable(out_cb) && $stable(out_cr))); // R4

  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (phase == PH_FOURTH || phase == PH_FIRST)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_y) && $stable(out_cb) && $stable(out_cr))); // R9

endmodule

// File: rtl/p422_demux.sv
module p422_demux
  import p422_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic          line_start,
  input  logic [DW-1:0] lo_byte,
  input  logic [DW-1:0] hi_byte,
  output logic [DW-1:0] pix_y,
  output logic [DW-1:0] pix_cb,
  output logic [DW-1:0] pix_cr,
  output logic          pix_valid
);

  grp_phase_t phase;
  cap_mode_e  mode_act;

  p422_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sol      (line_start),
    .mode_req (mode_sel),
    .phase    (phase),
    .mode_act (mode_act)
  );

  p422_capture #(.DW(DW)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .sol       (line_start),
    .phase     (phase),
    .mode_act  (mode_act),
    .lo        (lo_byte),
    .hi        (hi_byte),
    .out_y     (pix_y),
    .out_cb    (pix_cb),
    .out_cr    (pix_cr),
    .out_valid (pix_valid)
  );

endmodule

// File: tb/test_p422_demux.sv
`timescale 1ns/1ps
module test_p422_demux;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_sel = 1'b0;
  logic       line_start = 1'b0;
  logic [7:0] lo_byte = '0;
  logic [7:0] hi_byte = '0;
  logic [7:0] pix_y, pix_cb, pix_cr;
  logic       pix_valid;

  int checks = 0;
  int errors = 0;
  bit cur_wide = 1'b0;
  logic [7:0] lo_b [0:63];
  logic [7:0] hi_b [0:63];

  always #2.5 clk = ~clk;

  p422_demux i_p422_demux (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .line_start(line_start),
    .lo_byte(lo_byte), .hi_byte(hi_byte),
    .pix_y(pix_y), .pix_cb(pix_cb), .pix_cr(pix_cr), .pix_valid(pix_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected luma for capture index i (group position 2 or 3)
  function automatic logic [7:0] exp_y(input int i, input bit wide);
    int g = i - (i % 4);
    if (wide) return (i % 4 == 2) ? lo_b[g] : lo_b[g+2];
    return (i % 4 == 2) ? lo_b[g+1] : lo_b[g+3];
  endfunction

  function automatic logic [7:0] exp_cb(input int i, input bit wide);
    int g = i - (i % 4);
    return wide ? hi_b[g] : lo_b[g];
  endfunction

  function automatic logic [7:0] exp_cr(input int i, input bit wide);
    int g = i - (i % 4);
    return wide ? hi_b[g+2] : lo_b[g+2];
  endfunction

  // optional line-start cycle, then len captured cycles with random buses
  task automatic run_line(input int len, input bit do_sol, input bit mode_at_sol);
    if (do_sol) begin
      @(negedge clk);
      rst_n = 1'b1;
      line_start = 1'b1;
      mode_sel = mode_at_sol;
      lo_byte = 8'($urandom);
      hi_byte = 8'($urandom);
      @(posedge clk); #1;
      cur_wide = mode_at_sol;
      chk(pix_valid == 1'b0, "R5 valid low after line start", pix_valid, 0);
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rst_n = 1'b1;
      line_start = 1'b0;
      mode_sel = 1'($urandom); // R6: toggling mid-line must not matter
      lo_b[i] = 8'($urandom);
      hi_b[i] = 8'($urandom);
      lo_byte = lo_b[i];
      hi_byte = hi_b[i];
      @(posedge clk); #1;
      if (i % 4 < 2) begin
        chk(pix_valid == 1'b0, "R7 no strobe before group complete", pix_valid, 0);
      end else begin
        chk(pix_valid == 1'b1, "R4 strobe on 3rd/4th edge", pix_valid, 1);
        chk(pix_y == exp_y(i, cur_wide),
            cur_wide ? "R3 wide luma" : "R2 narrow luma", pix_y, exp_y(i, cur_wide));
        chk(pix_cb == exp_cb(i, cur_wide),
            cur_wide ? "R3 wide Cb" : "R2 narrow Cb (R8 hi ignored)", pix_cb, exp_cb(i, cur_wide));
        chk(pix_cr == exp_cr(i, cur_wide),
            cur_wide ? "R3 wide Cr" : "R2 narrow Cr (R8 hi ignored)", pix_cr, exp_cr(i, cur_wide));
      end
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] hy, hcb, hcr;
    void'($urandom(32'd4177));
    repeat (3) @(posedge clk);
    #1;
    chk(pix_valid == 1'b0, "R1 reset valid", pix_valid, 0);
    chk(pix_y == 8'h00 && pix_cb == 8'h00 && pix_cr == 8'h00, "R1 reset data", pix_y, 0);
    // first cycle after reset release: default narrow, no strobe
    cur_wide = 1'b0;
    run_line(12, 1'b0, 1'b0);            // R1 default narrow layout
    run_line(8, 1'b1, 1'b0);             // R2
    run_line(16, 1'b1, 1'b1);            // R3
    run_line(6, 1'b1, 1'b1);             // R7 cut-short group
    run_line(5, 1'b1, 1'b0);             // R5 restart mid group
    run_line(0, 1'b1, 1'b1);             // back-to-back line starts
    run_line(9, 1'b1, 1'b1);
    // R9 / R7: truncated group then line start keeps outputs frozen
    hy = pix_y; hcb = pix_cb; hcr = pix_cr;
    run_line(0, 1'b1, 1'b0);
    chk(pix_y == hy && pix_cb == hcb && pix_cr == hcr, "R9 outputs held", pix_y, hy);
    run_line(2, 1'b0, 1'b0);
    chk(pix_y == hy && pix_cb == hcb && pix_cr == hcr, "R9 outputs held mid group", pix_y, hy);
    for (int n = 0; n < 60; n++) begin
      run_line(int'($urandom % 31), 1'b1, 1'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule